// File: doc/BRIEF.md
# Programmable Backplane Multiplex Sequencer

This block scans a display memory to produce the time-multiplexed drive for a segment display of up to 8 backplanes by 16 columns. At each phase tick it moves to the next active backplane. It asserts exactly one backplane select for that backplane and presents the 16 column bits read from the display memory row of the same index. The number of active backplanes can be set from 1 to 8. A polarity flag flips once per completed frame, so that the analog drive stage downstream can keep the net DC across each segment at zero.

The phase tick comes from one of two places. It can be an internal clock-enable pulse. It can also be the rising edge of an external oscillator signal. For cascaded displays the block can run as a slave. In that mode it ignores its own counter and copies the backplane index from the one-hot backplane lines of a master controller.

Top module: `bp_mux_seq`

## Requirements
- R1: After reset `bpOut` and `colOut` are all zero and `polarity` is 0. They stay so until the first phase tick, and that tick selects backplane 0.
- R2: In master mode each phase tick moves the backplane index from 0 up to N-1 and then back to 0, where N is the active count. At most one bit of `bpOut` is set, and bit k selects backplane k.
- R3: `ramAddr` gives the index that the next tick will enter. On a tick, `colOut` loads `ramRdData`. Both `bpOut` and `colOut` change at the clock edge where the tick is sampled.
- R4: A `bpCount` of 0 acts as 1 and a value above 8 acts as 8. In master mode, backplanes at or above N are never selected.
- R5: A new `bpCount` is taken into use only when the sequence re-enters backplane 0. The frame in progress completes with the old count.
- R6: `polarity` toggles on every tick that re-enters backplane 0 while the block is already running. This is once per frame; with N=1 it is every tick. The first tick after reset or idle does not toggle it.
- R7: With no phase tick, `bpOut`, `colOut` and `polarity` hold their values.
- R8: With `useExtOsc`=1 the phase tick is a rising edge of `extOsc`, meaning high now and low on the previous clock; `tickInt` is then ignored. With `useExtOsc`=0, `tickInt` is the tick and `extOsc` is ignored.
- R9: With `slaveMode`=1, each tick enters the backplane given by the lowest set bit of `extBp`, and `bpCount` only sets the stored N. A tick while `extBp` is all zero clears `bpOut` and `colOut` and makes the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickInt | input | 1 | Internal phase clock-enable |
| extOsc | input | 1 | External oscillator level, synchronous to clk |
| useExtOsc | input | 1 | Selects the external oscillator as tick source |
| slaveMode | input | 1 | Follow the external backplane lines |
| extBp | input | 8 | Master's backplane selects, one-hot |
| bpCount | input | 4 | Programmed number of active backplanes |
| ramAddr | output | 3 | Display memory row to read |
| ramRdData | input | 16 | Row data returned for ramAddr, same cycle |
| bpOut | output | 8 | Backplane selects |
| colOut | output | 16 | Column data for the active backplane |
| polarity | output | 1 | Frame drive phase flag |

## Verification
The assertions assume three things about the inputs. `ramRdData` is a combinational function of `ramAddr`. `extOsc` and `extBp` are already synchronous to `clk`. In slave mode `extBp` is one-hot when a tick arrives, unless it is deliberately all zero. The bench drives every input on the falling clock edge and returns the memory row from a model array indexed by `ramAddr`. It holds `extOsc` high for several clocks so that each rising edge is a clean single tick. It applies non-one-hot `extBp` patterns only as the all-zero idle case.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  typedef struct packed {
    logic load;   // enter the backplane on nextIdx
    logic clear;  // blank all outputs (slave with no master select)
  } bpmStrobes_t;
endpackage

// File: rtl/bpm_ctrl.sv
module bpm_ctrl
  import bpm_pkg::*;
#(
  parameter int NUM_BP = 8,
  localparam int IDX_W = $clog2(NUM_BP),
  localparam int CNT_W = $clog2(NUM_BP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickInt,
  input  logic             extOsc,
  input  logic             useExtOsc,
  input  logic             slaveMode,
  input  logic [NUM_BP-1:0] extBp,
  input  logic [CNT_W-1:0] bpCount,
  output logic [IDX_W-1:0] nextIdx,
  output bpmStrobes_t      strobes,
  output logic             polarity
);
  logic             oscPrev;
  logic             running;
  logic [IDX_W-1:0] curIdx;
  logic [CNT_W-1:0] curN;
  logic [CNT_W-1:0] effN;
  logic [IDX_W-1:0] slaveIdx;
  logic             tick;
  logic             goIdle;

  // phase tick source
  always_comb tick = useExtOsc ? (extOsc & ~oscPrev) : tickInt;

  // clamp the programmed count into 1..NUM_BP
  always_comb begin
    if (bpCount == '0)                      effN = CNT_W'(1);
    else if (bpCount > CNT_W'(NUM_BP))      effN = CNT_W'(NUM_BP);
    else                                    effN = bpCount;
  end

  // lowest set bit of the master's backplane lines
  always_comb begin
    slaveIdx = '0;
    for (int i = NUM_BP - 1; i >= 0; i--)
      if (extBp[i]) slaveIdx = IDX_W'(i);
  end

  always_comb begin
    if (slaveMode) begin
      nextIdx = slaveIdx;
      goIdle  = ~|extBp;
    end else begin
      goIdle  = 1'b0;
      if (!running || CNT_W'(curIdx) >= curN - CNT_W'(1)) nextIdx = '0;
      else                                                nextIdx = curIdx + IDX_W'(1);
    end
    strobes.load  = tick & ~goIdle;
    strobes.clear = tick & goIdle;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oscPrev  <= 1'b0;
      running  <= 1'b0;
      curIdx   <= '0;
      curN     <= CNT_W'(1);
      polarity <= 1'b0;
    end else begin
      oscPrev <= extOsc;
      if (strobes.clear) begin
        running <= 1'b0;
      end else if (strobes.load) begin
        running <= 1'b1;
        curIdx  <= nextIdx;
        if (nextIdx == '0) begin
          curN <= effN;
          if (running) polarity <= ~polarity;
        end
      end
    end
  end
endmodule

// File: rtl/bpm_datapath.sv
module bpm_datapath
  import bpm_pkg::*;
#(
  parameter int NUM_BP  = 8,
  parameter int NUM_COL = 16,
  localparam int IDX_W  = $clog2(NUM_BP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bpmStrobes_t        strobes,
  input  logic [IDX_W-1:0]   nextIdx,
  input  logic [NUM_COL-1:0] ramRdData,
  output logic [NUM_BP-1:0]  bpOut,
  output logic [NUM_COL-1:0] colOut
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bpOut  <= '0;
      colOut <= '0;
    end else if (strobes.clear) begin
      bpOut  <= '0;
      colOut <= '0;
    end else if (strobes.load) begin
      bpOut  <= NUM_BP'(1) << nextIdx;
      colOut <= ramRdData;
    end
  end
endmodule

// File: rtl/bp_mux_seq.sv
module bp_mux_seq
  import bpm_pkg::*;
#(
  parameter int NUM_BP  = 8,
  parameter int NUM_COL = 16,
  localparam int IDX_W  = $clog2(NUM_BP),
  localparam int CNT_W  = $clog2(NUM_BP + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tickInt,
  input  logic               extOsc,
  input  logic               useExtOsc,
  input  logic               slaveMode,
  input  logic [NUM_BP-1:0]  extBp,
  input  logic [CNT_W-1:0]   bpCount,
  output logic [IDX_W-1:0]   ramAddr,
  input  logic [NUM_COL-1:0] ramRdData,
  output logic [NUM_BP-1:0]  bpOut,
  output logic [NUM_COL-1:0] colOut,
  output logic               polarity
);
  bpmStrobes_t      strobes;
  logic [IDX_W-1:0] nextIdx;

  bpm_ctrl #(.NUM_BP(NUM_BP)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tickInt(tickInt), .extOsc(extOsc),
    .useExtOsc(useExtOsc), .slaveMode(slaveMode), .extBp(extBp),
    .bpCount(bpCount), .nextIdx(nextIdx), .strobes(strobes),
    .polarity(polarity)
  );

  bpm_datapath #(.NUM_BP(NUM_BP), .NUM_COL(NUM_COL)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .nextIdx(nextIdx),
    .ramRdData(ramRdData), .bpOut(bpOut), .colOut(colOut)
  );

  assign ramAddr = nextIdx;
endmodule

// File: rtl/bpm_checker.sv
module bpm_checker #(
  parameter int NUM_BP  = 8,
  parameter int NUM_COL = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tickInt,
  input logic               useExtOsc,
  input logic               slaveMode,
  input logic [NUM_BP-1:0]  extBp,
  input logic [NUM_COL-1:0] ramRdData,
  input logic [NUM_BP-1:0]  bpOut,
  input logic [NUM_COL-1:0] colOut,
  input logic               polarity
);
  AST_BP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bpOut)); // R2

  AST_COL_FROM_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (!useExtOsc && tickInt && !slaveMode) |=> colOut == $past(ramRdData)); // R3

  AST_POL_AT_BP0: assert property (@(posedge clk) disable iff (!rst_n)
    (polarity != $past(polarity)) |-> bpOut[0]); // R6

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!useExtOsc && !tickInt) |=> ($stable(bpOut) && $stable(colOut) && $stable(polarity))); // R7

  AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!useExtOsc && tickInt && slaveMode && $onehot(extBp)) |=> bpOut == $past(extBp)); // R9
endmodule

bind bp_mux_seq bpm_checker #(.NUM_BP(NUM_BP), .NUM_COL(NUM_COL)) chk_i (
  .clk(clk), .rst_n(rst_n), .tickInt(tickInt), .useExtOsc(useExtOsc),
  .slaveMode(slaveMode), .extBp(extBp), .ramRdData(ramRdData),
  .bpOut(bpOut), .colOut(colOut), .polarity(polarity)
);

// File: tb/bp_mux_seq_tb.sv
module bp_mux_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickInt = 1'b0;
  logic        extOsc = 1'b0;
  logic        useExtOsc = 1'b0;
  logic        slaveMode = 1'b0;
  logic [7:0]  extBp = '0;
  logic [3:0]  bpCount = 4'd3;
  logic [2:0]  ramAddr;
  logic [15:0] ramRdData;
  logic [7:0]  bpOut;
  logic [15:0] colOut;
  logic        polarity;

  logic [15:0] mem [8];
  int checks = 0;
  int errors = 0;

  // model state
  int  mIdx = 0;
  int  mN = 1;
  bit  mRun = 0;
  bit  mPol = 0;
  logic [7:0]  eBp = '0;
  logic [15:0] eCol = '0;

  always #5 clk = ~clk;

  assign ramRdData = mem[ramAddr];

  bp_mux_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tickInt(tickInt), .extOsc(extOsc),
    .useExtOsc(useExtOsc), .slaveMode(slaveMode), .extBp(extBp),
    .bpCount(bpCount), .ramAddr(ramAddr), .ramRdData(ramRdData),
    .bpOut(bpOut), .colOut(colOut), .polarity(polarity)
  );

  function automatic int effCount(input logic [3:0] c);
    if (c == 0) return 1;
    if (c > 8) return 8;
    return int'(c);
  endfunction

  // expected effect of one phase tick, from the requirements
  task automatic modelTick();
    int nxt;
    if (slaveMode) begin
      if (extBp == 0) begin
        mRun = 0; eBp = '0; eCol = '0; return;
      end
      nxt = 0;
      for (int i = 7; i >= 0; i--) if (extBp[i]) nxt = i;
    end else begin
      nxt = (!mRun || mIdx >= mN - 1) ? 0 : mIdx + 1;
    end
    if (nxt == 0) begin
      if (mRun) mPol = ~mPol;
      mN = effCount(bpCount);
    end
    mIdx = nxt; mRun = 1;
    eBp = 8'(1) << nxt;
    eCol = mem[nxt];
  endtask

  task automatic check(input string tag);
    checks++;
    if (bpOut !== eBp || colOut !== eCol || polarity !== mPol) begin
      errors++;
      $display("FAIL %s: bp=%b col=%h pol=%b expected bp=%b col=%h pol=%b",
               tag, bpOut, colOut, polarity, eBp, eCol, mPol);
    end
  endtask

  task automatic pulseTick(input string tag);
    @(negedge clk) tickInt = 1'b1;
    @(negedge clk) tickInt = 1'b0;
    if (!useExtOsc) modelTick();
    check(tag);
  endtask

  task automatic testReset();
    check("R1 reset state");
    repeat (3) @(negedge clk);
    check("R1 idle before tick");
    checks++;
    if (ramAddr !== 3'd0) begin
      errors++;
      $display("FAIL R1 first address: got %0d expected 0", ramAddr);
    end
  endtask

  task automatic testMasterSweep();
    bpCount = 4'd3;
    for (int k = 0; k < 7; k++) pulseTick("R2 R3 R6 sweep N=3");
  endtask

  task automatic testHold();
    repeat (6) @(negedge clk);
    check("R7 hold without tick");
  endtask

  task automatic testCountChange();
    pulseTick("R5 before change");
    bpCount = 4'd5;
    for (int k = 0; k < 9; k++) pulseTick("R5 count change at frame edge");
  endtask

  task automatic testClamp();
    bpCount = 4'd0;
    for (int k = 0; k < 8; k++) pulseTick("R4 zero count acts as one");
    bpCount = 4'd12;
    for (int k = 0; k < 10; k++) pulseTick("R4 large count clamps to eight");
  endtask

  task automatic testExtOsc();
    useExtOsc = 1'b1;
    pulseTick("R8 internal tick ignored");
    @(negedge clk) extOsc = 1'b1;
    repeat (4) @(negedge clk);
    modelTick();
    check("R8 one step per osc edge");
    extOsc = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 falling edge no step");
    @(negedge clk) extOsc = 1'b1;
    @(negedge clk) extOsc = 1'b0;
    modelTick();
    check("R8 second osc edge");
    repeat (2) @(negedge clk);
    useExtOsc = 1'b0;
  endtask

  task automatic testSlave();
    slaveMode = 1'b1;
    bpCount = 4'd2;
    extBp = 8'b0010_0000;
    pulseTick("R9 follow master bp5");
    extBp = 8'b1000_0000;
    pulseTick("R9 beyond own count");
    extBp = 8'b0000_0001;
    pulseTick("R9 R6 re-enter bp0");
    extBp = 8'b0000_0000;
    pulseTick("R9 no master select blanks");
    extBp = 8'b0000_0001;
    pulseTick("R9 R6 restart without toggle");
    extBp = 8'b0000_0100;
    pulseTick("R9 follow bp2");
    slaveMode = 1'b0;
    extBp = '0;
    pulseTick("R2 back to master wraps");
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 16'hA500 ^ (16'(i) * 16'h1111);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testMasterSweep();
    testHold();
    testCountChange();
    testClamp();
    testExtOsc();
    testSlave();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule